// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block watches the command pins and the clock-enable input of a synchronous DRAM device, one sample per rising clock edge, and keeps track of which power state the memory is in. The states are: all banks closed, at least one bank open, precharge power-down, active power-down (which also covers clock suspend), and self refresh. It also keeps a per-bank open/closed mask, driven by activate, precharge and auto-precharge commands.

Every edge, the block reports whether the command sampled at that edge was taken or was illegal for the current state. Illegal commands have no effect on the bank mask. A state change depends on two clock-enable samples taken across two edges. The earlier sample is not kept in its own register; the power state encodes it. After the memory leaves self refresh, a lockout of a parameterised number of edges covers the refresh-cycle time. During the lockout, any command other than no-op or deselect is refused.

All outputs are registered. The effect of the inputs sampled at edge N is visible just after edge N. Typical use is as a protocol monitor beside a memory model, or in front of a memory controller's checker.

Top module: `sdr_pwr_tracker`

## Requirements
- R1: While `rst` is high, the next edge sets `pwr_state` to 0 (idle), clears `bank_open`, and clears `cmd_illegal`, `cmd_taken` and `exit_busy`. State codes are: 0 idle, 1 active, 2 precharge power-down, 3 active power-down or clock suspend, 4 self refresh.
- R2: With `cs_n` high, the command is deselect and is handled exactly like a no-op, whatever `ras_n`, `cas_n` and `we_n` carry.
- R3: With chip select low and clock enable high, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 001 auto refresh, 000 mode set, 111 no-op. Activate sets the `bank_open` bit selected by `ba`. Precharge clears that bit, or clears all bits when `a10` is 1. A read or write with `a10` at 1 clears its bank. The state is 1 when any bank is open and 0 otherwise.
- R4: With clock enable high, the following commands are illegal: activate to an open bank, read or write to a closed bank, and mode set while any bank is open. An illegal command raises `cmd_illegal` and changes nothing. A legal command other than no-op or deselect raises `cmd_taken`.
- R5: Auto refresh is taken only with clock enable high on both samples and all banks closed. If any bank is open, it is illegal.
- R6: Clock enable low with no-op or deselect enters state 2 when no bank is open, and state 3 when any bank is open. `bank_open` is kept.
- R7: Clock enable falling together with any command other than no-op, deselect or auto refresh flags the command illegal and does not execute it. The power-down entry of R6 still happens.
- R8: In state 2 or 3, command pins are ignored while clock enable stays low. Clock enable high returns the state to 1 or 0, according to the bank mask. A non-no-op command on that exit edge is flagged illegal. The next edge accepts commands normally.
- R9: Auto refresh sampled with clock enable low, all banks closed and no lockout running enters state 4.
- R10: Auto refresh with clock enable low while a bank is open is flagged illegal and enters state 3.
- R11: In state 4, clock enable high returns to state 0. `exit_busy` is then high for LOCK edges, where LOCK = ceil(TRFC_PS/TCK_PS) − 1, which is 6 by default. At those edges, every command other than no-op or deselect is flagged illegal and ignored. The first command accepted comes LOCK+1 edges after the exit edge.
- R12: `cmd_illegal` and `cmd_taken` are single-edge results for the command sampled at that edge, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable sample |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | All-banks / auto-precharge flag |
| pwr_state | output | 3 | Power state code (R1) |
| bank_open | output | NUM_BANKS | Open-bank mask |
| cmd_illegal | output | 1 | Sampled command was illegal |
| cmd_taken | output | 1 | Sampled command was executed |
| exit_busy | output | 1 | Self-refresh exit lockout running |

## Verification
The assertions check several rules on every cycle. The two power-down states must agree with the bank mask, and the mask stays frozen through power-down. Self refresh is only reached from a low clock-enable sample with every bank closed, and it only exits into idle with the lockout raised. No command is taken while the lockout is raised, and the illegal and taken flags are never high together. Other behaviour needs the bench's scenarios and its reference model, because it depends on what was on the command pins: which commands count as illegal, the exact lockout length, ignored deselects, and auto-precharge closing a bank.

// File: rtl/sdr_pwr_pkg.sv
package sdr_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_ACTIVE   = 3'd1,
    PS_PRE_PD   = 3'd2,
    PS_ACT_PD   = 3'd3,
    PS_SELF_REF = 3'd4
  } pwr_state_e;

  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_BST,
    CMD_AREF,
    CMD_MRS
  } cmd_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pwr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic is_idle_cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;                       // R2: chip select high gates the strobes
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_BST;
        3'b001:  cmd = CMD_AREF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign is_idle_cmd = (cmd == CMD_DESEL) || (cmd == CMD_NOP);

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
  import sdr_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic                 exec_en,
  output logic                 legal,
  output logic [NUM_BANKS-1:0] open_q,
  output logic [NUM_BANKS-1:0] open_d,
  output logic                 any_open
);

  logic [NUM_BANKS-1:0] sel;
  logic                 sel_open;
  logic                 update;

  assign any_open = |open_q;
  assign sel_open = |(sel & open_q);

  // R4/R5: legality against the current mask
  always_comb begin
    case (cmd)
      CMD_ACT:             legal = !sel_open;
      CMD_READ, CMD_WRITE: legal = sel_open;
      CMD_AREF, CMD_MRS:   legal = !any_open;
      default:             legal = 1'b1;
    endcase
  end

  assign update = exec_en && legal;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic set_b;
    logic clr_b;

    assign sel[g] = (ba == BA_W'(g));
    assign set_b  = (cmd == CMD_ACT) && sel[g];
    assign clr_b  = ((cmd == CMD_PRE) && (a10 || sel[g])) ||
                    (((cmd == CMD_READ) || (cmd == CMD_WRITE)) && a10 && sel[g]);

    assign open_d[g] = update ? ((open_q[g] | set_b) & ~clr_b) : open_q[g];

    always_ff @(posedge clk) begin
      if (rst) open_q[g] <= 1'b0;
      else     open_q[g] <= open_d[g];
    end
  end

endmodule

// File: rtl/sdr_exit_timer.sv
module sdr_exit_timer #(
  parameter int LOCK_CYC = 6,
  parameter int CNT_W    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= CNT_W'(LOCK_CYC);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/sdr_pwr_tracker.sv
module sdr_pwr_tracker
  import sdr_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int TCK_PS    = 10000,
  parameter int TRFC_PS   = 65000,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic [2:0]           pwr_state,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 cmd_illegal,
  output logic                 cmd_taken,
  output logic                 exit_busy
);

  localparam int LOCK_RAW = (TRFC_PS + TCK_PS - 1) / TCK_PS - 1;
  localparam int LOCK_CYC = (LOCK_RAW > 0) ? LOCK_RAW : 0;
  localparam int CNT_W    = (LOCK_CYC > 0) ? $clog2(LOCK_CYC + 1) : 1;

  cmd_e                 cmd;
  logic                 idle_cmd;
  logic                 legal;
  logic                 any_open;
  logic [NUM_BANKS-1:0] open_d;
  logic                 exec_en;
  logic                 lock_load;
  logic                 busy;

  pwr_state_e state_q, state_d;
  logic       ill_d, take_d;
  logic       ill_q, take_q;

  sdr_cmd_decode u_dec (
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .cmd         (cmd),
    .is_idle_cmd (idle_cmd)
  );

  sdr_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .ba       (ba),
    .a10      (a10),
    .exec_en  (exec_en),
    .legal    (legal),
    .open_q   (bank_open),
    .open_d   (open_d),
    .any_open (any_open)
  );

  sdr_exit_timer #(
    .LOCK_CYC (LOCK_CYC),
    .CNT_W    (CNT_W)
  ) u_lock (
    .clk  (clk),
    .rst  (rst),
    .load (lock_load),
    .busy (busy)
  );

  // The earlier clock-enable sample is implied by the state:
  // idle/active means it was high, the low-power states mean it was low.
  always_comb begin
    state_d   = state_q;
    ill_d     = 1'b0;
    take_d    = 1'b0;
    exec_en   = 1'b0;
    lock_load = 1'b0;
    case (state_q)
      PS_PRE_PD, PS_ACT_PD: begin
        if (cke) begin                                   // R8 exit
          state_d = any_open ? PS_ACTIVE : PS_IDLE;
          ill_d   = !idle_cmd;
        end
      end
      PS_SELF_REF: begin
        if (cke) begin                                   // R11 exit
          state_d   = PS_IDLE;
          lock_load = 1'b1;
          ill_d     = !idle_cmd;
        end
      end
      default: begin
        if (busy && !idle_cmd) ill_d = 1'b1;             // R11 lockout
        if (!cke) begin
          if ((cmd == CMD_AREF) && !busy) begin
            if (any_open) begin                          // R10
              ill_d   = 1'b1;
              state_d = PS_ACT_PD;
            end else begin                               // R9
              state_d = PS_SELF_REF;
            end
          end else begin                                 // R6/R7
            if (!idle_cmd) ill_d = 1'b1;
            state_d = any_open ? PS_ACT_PD : PS_PRE_PD;
          end
        end else begin                                   // R3/R4/R5
          exec_en = !busy && !idle_cmd;
          if (exec_en) begin
            ill_d  = !legal;
            take_d = legal;
          end
          state_d = (|open_d) ? PS_ACTIVE : PS_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      ill_q   <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
      take_q  <= take_d;
    end
  end

  assign pwr_state   = state_q;
  assign cmd_illegal = ill_q;
  assign cmd_taken   = take_q;
  assign exit_busy   = busy;

endmodule

// File: rtl/sdr_pwr_tracker_chk.sv
module sdr_pwr_tracker_chk #(
  parameter int NUM_BANKS = 2,
  parameter int TCK_PS    = 10000,
  parameter int TRFC_PS   = 65000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic [2:0]           pwr_state,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 cmd_illegal,
  input logic                 cmd_taken,
  input logic                 exit_busy
);

  localparam int LOCK_RAW = (TRFC_PS + TCK_PS - 1) / TCK_PS - 1;
  localparam bit HAS_LOCK = (LOCK_RAW > 0);

  logic in_pd;
  assign in_pd = (pwr_state == 3'd2) || (pwr_state == 3'd3);

  assert_idle_closed_R3: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd0) |-> (bank_open == '0));

  assert_active_open_R3: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd1) |-> (bank_open != '0));

  assert_prepd_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd2) |-> (bank_open == '0));

  assert_actpd_open_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd3) |-> (bank_open != '0));

  assert_pd_mask_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    in_pd |=> $stable(bank_open));

  assert_pd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_pd && !cke) |=> (pwr_state == $past(pwr_state)));

  assert_sr_entry_R9: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == 3'd4) && ($past(pwr_state) != 3'd4)) |->
      (($past(bank_open) == '0) && !$past(cke)));

  assert_sr_exit_R11: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd4) |=>
      ((pwr_state == 3'd4) || ((pwr_state == 3'd0) && (exit_busy == HAS_LOCK))));

  assert_lock_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    exit_busy |=> !cmd_taken);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(cmd_illegal && cmd_taken));

endmodule

bind sdr_pwr_tracker sdr_pwr_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .TCK_PS    (TCK_PS),
  .TRFC_PS   (TRFC_PS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .pwr_state   (pwr_state),
  .bank_open   (bank_open),
  .cmd_illegal (cmd_illegal),
  .cmd_taken   (cmd_taken),
  .exit_busy   (exit_busy)
);

// File: tb/sdr_pwr_tracker_tb.sv
module sdr_pwr_tracker_tb;

  localparam int NB   = 2;
  localparam int LOCK = (65000 + 10000 - 1) / 10000 - 1;

  localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1011, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                         C_AREF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [0:0] ba;
  logic [2:0] pwr_state;
  logic [NB-1:0] bank_open;
  logic cmd_illegal, cmd_taken, exit_busy;

  int checks = 0, failures = 0;
  logic [2:0]    m_st;
  logic [NB-1:0] m_open;
  int            m_cnt;
  logic          m_ill, m_take;

  always #5 clk = ~clk;

  sdr_pwr_tracker #(.NUM_BANKS(NB), .TCK_PS(10000), .TRFC_PS(65000)) u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .pwr_state(pwr_state), .bank_open(bank_open),
    .cmd_illegal(cmd_illegal), .cmd_taken(cmd_taken), .exit_busy(exit_busy));

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Reference model built from the requirement text
  task automatic model(input logic k, input logic [3:0] c, input logic b, input logic a);
    logic nop;
    logic [2:0] op;
    logic busy;
    logic ok;
    logic [NB-1:0] nxt;
    nop  = c[3] || (c[2:0] == 3'b111);
    op   = c[2:0];
    m_ill = 1'b0; m_take = 1'b0;
    busy = (m_cnt != 0);
    if (busy) m_cnt--;
    case (m_st)
      3'd2, 3'd3: if (k) begin m_st = (m_open != 0) ? 3'd1 : 3'd0; m_ill = !nop; end
      3'd4:       if (k) begin m_st = 3'd0; m_cnt = LOCK; m_ill = !nop; end
      default: begin
        if (busy && !nop) m_ill = 1'b1;
        if (!k) begin
          if (!nop && op == 3'b001 && !busy) begin
            if (m_open != 0) begin m_ill = 1'b1; m_st = 3'd3; end
            else m_st = 3'd4;
          end else begin
            if (!nop) m_ill = 1'b1;
            m_st = (m_open != 0) ? 3'd3 : 3'd2;
          end
        end else begin
          if (!busy && !nop) begin
            nxt = m_open;
            case (op)
              3'b011: begin ok = !m_open[b]; nxt[b] = 1'b1; end
              3'b101, 3'b100: begin ok = m_open[b]; if (a) nxt[b] = 1'b0; end
              3'b010: begin ok = 1'b1; if (a) nxt = '0; else nxt[b] = 1'b0; end
              3'b001, 3'b000: ok = (m_open == 0);
              default: ok = 1'b1;
            endcase
            m_ill = !ok; m_take = ok;
            if (ok) m_open = nxt;
          end
          m_st = (m_open != 0) ? 3'd1 : 3'd0;
        end
      end
    endcase
  endtask

  task automatic check(input string tag);
    logic [7:0] act, exp;
    act = {pwr_state, bank_open, cmd_illegal, cmd_taken, exit_busy};
    exp = {m_st, m_open, m_ill, m_take, (m_cnt != 0)};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s state/banks/ill/take/busy actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c, input logic b, input logic a,
                      input string tag);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; a10 = a;
    model(k, c, b, a);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = C_NOP; ba = 0; a10 = 0;
    m_st = 0; m_open = 0; m_cnt = 0; m_ill = 0; m_take = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");                                    // reset state
    rst = 1'b0;

    step(1, C_ACT, 0, 0, "R3");                     // open bank 0
    step(1, C_RD,  1, 0, "R4");                     // read closed bank
    step(1, C_ACT, 0, 0, "R4");                     // reopen open bank
    step(1, C_MRS, 0, 0, "R4");                     // mode set with open bank
    step(1, C_AREF, 0, 0, "R5");                    // refresh with open bank
    step(0, C_NOP, 0, 0, "R6");                     // active power-down
    step(0, C_ACT, 1, 0, "R8");                     // ignored while held low
    step(1, C_NOP, 0, 0, "R8");                     // exit
    step(1, C_RD,  0, 1, "R3");                     // auto-precharge closes bank 0
    step(1, 4'b1011 & C_DES | 4'b1000, 1, 0, "R2"); // deselect with activate strobes
    step(1, C_NOP, 0, 0, "R2");
    step(0, C_WR,  0, 0, "R7");                     // write with cke falling
    step(1, C_ACT, 1, 0, "R8");                     // command on exit edge
    step(1, C_AREF, 0, 0, "R5");                    // legal refresh
    step(1, C_ACT, 1, 0, "R3");
    step(0, C_AREF, 0, 0, "R10");                   // self-refresh entry with open bank
    step(1, C_NOP, 0, 0, "R8");
    step(1, C_PRE, 0, 1, "R3");                     // precharge all
    step(0, C_AREF, 0, 0, "R9");                    // self refresh
    step(0, C_NOP, 0, 0, "R9");
    step(0, C_ACT, 0, 0, "R9");
    step(1, C_NOP, 0, 0, "R11");                    // exit, lockout starts
    for (int i = 0; i < LOCK; i++) step(1, C_ACT, 0, 0, "R11");
    step(1, C_ACT, 0, 0, "R11");                    // first accepted command
    step(1, C_PRE, 0, 1, "R3");
    step(0, C_DES, 0, 0, "R6");                     // precharge power-down
    step(1, C_DES, 0, 0, "R8");

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic k;
      logic [3:0] c;
      k = (($urandom % 8) != 0);
      c = 4'($urandom);
      if (($urandom % 3) == 0) c[3] = 1'b0;
      step(k, c, 1'($urandom), 1'($urandom), "R12");
    end

    report();
    $finish;
  end

endmodule